// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters from a host into an asynchronous serial stream. The host writes a character into a holding register with a one-cycle load strobe. When the serializer is free, the character moves into a shift register. It is then sent as a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. All bit timing comes from a clock enable `tick` that pulses at sixteen times the bit rate. Each bit therefore lasts sixteen tick periods.

A `ready` flag shows that the holding register is empty. It drops when a character is accepted. It rises again as soon as that character moves into the shift register. The host can therefore queue a second character while the first is still on the line. The two frames then leave with no idle gap between them.

The start bit always begins on a tick edge, so it is never shortened by the timing of the load. An interrupt request combines `ready` with an enable input. The format inputs (parity on or off, odd or even, one or two stops) are captured together with each character when it moves into the shift register.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset, and whenever no character is held or being shifted, `txd` is 1 (mark) and `ready` is 1.
- R2: A load strobe taken while `ready` is 1 makes `ready` 0 on the next cycle. `ready` returns to 1 on the tick edge where the character enters the shift register.
- R3: A load strobe while `ready` is 0 is ignored: the held character is unchanged and no extra frame is sent.
- R4: A character loaded while the previous one is being shifted follows it with no idle time: its start bit begins on the tick edge where the last stop bit ends.
- R5: Every falling edge of `txd` occurs on a tick edge. From idle, the start bit falls on the first tick edge after the cycle that took the load.
- R6: Every bit, including the start bit, lasts exactly 16 tick periods.
- R7: The frame is: start (0), then data bits with bit 0 first, then parity if `cfg_par_en` is 1, then the stop bits (1).
- R8: With `cfg_par_odd` = 0 the ones in data plus parity are even in number; with `cfg_par_odd` = 1 they are odd.
- R9: `cfg_two_stop` = 0 sends one stop bit and `cfg_two_stop` = 1 sends two.
- R10: `irq` equals `ready` AND `irq_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable at 16 times the bit rate |
| load | input | 1 | Write strobe for the holding register |
| din | input | DATA_W | Character to send |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 sends two stop bits |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial output, idle high |
| ready | output | 1 | Holding register empty |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the hand-over at the end of a frame. At that moment the holding register must already be full, and any further strobe must bounce off it. The stimulus loads the first character from idle and waits for `ready` to come back at the transfer. It then loads the second character at once, so it is waiting before the first frame ends. On some pairs a third strobe is fired while the register is full. The line monitor then requires the second start bit exactly at the last stop boundary, with no stray frame after it. This is swept over every 5-bit value under all eight format settings.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } txb_fmt_t;
endpackage

// File: rtl/txb_hold.sv
module txb_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic              ready,
  output logic [DATA_W-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready  <= 1'b1;
      hold_q <= '0;
    end else if (load && ready) begin
      ready  <= 1'b0;
      hold_q <= din;
    end else if (take) begin
      ready  <= 1'b1;
    end
  end
endmodule

// File: rtl/txb_serializer.sv
module txb_serializer
  import txb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pending,
  input  logic [DATA_W-1:0] data,
  input  txb_fmt_t          fmt,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FW = DATA_W + 3;
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int NW = $clog2(FW + 2);

  logic [CW-1:0] sub_cnt;
  logic [NW-1:0] bits_left;
  logic [FW-1:0] shreg;
  logic [FW-1:0] frame;
  logic [NW-1:0] frame_len;
  logic          par_bit;
  logic          bit_end;
  logic          last_bit;

  always_comb begin
    par_bit   = fmt.par_odd ? ~^data : ^data;
    frame     = fmt.par_en ? {2'b11, par_bit, data} : {3'b111, data};
    frame_len = NW'(DATA_W + 2) + NW'(fmt.par_en) + NW'(fmt.two_stop);
    bit_end   = (sub_cnt == CW'(OVS - 1));
    last_bit  = bit_end && (bits_left == NW'(1));
    take      = tick && pending && (!busy || last_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= 1'b1;
      busy      <= 1'b0;
      sub_cnt   <= '0;
      bits_left <= '0;
      shreg     <= '1;
    end else if (take) begin
      txd       <= 1'b0;
      busy      <= 1'b1;
      sub_cnt   <= '0;
      bits_left <= frame_len;
      shreg     <= frame;
    end else if (tick && busy) begin
      if (bit_end) begin
        sub_cnt <= '0;
        if (last_bit) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd       <= shreg[0];
          shreg     <= {1'b1, shreg[FW-1:1]};
          bits_left <= bits_left - NW'(1);
        end
      end else begin
        sub_cnt <= sub_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import txb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              irq_en,
  output logic              txd,
  output logic              ready,
  output logic              irq
);
  logic              take;
  logic              sh_busy;
  logic              pending;
  logic [DATA_W-1:0] hold_q;
  txb_fmt_t          fmt;

  assign fmt     = '{par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign pending = ~ready;
  assign irq     = ready & irq_en;

  txb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .din   (din),
    .take  (take),
    .ready (ready),
    .hold_q(hold_q)
  );

  txb_serializer #(.DATA_W(DATA_W), .OVS(OVS)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .pending(pending),
    .data   (hold_q),
    .fmt    (fmt),
    .take   (take),
    .busy   (sh_busy),
    .txd    (txd)
  );
endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              load,
  input logic              ready,
  input logic              txd,
  input logic              busy,
  input logic [DATA_W-1:0] hold_q
);
  // R2
  load_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (load && ready) |=> !ready);

  // R2
  ready_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(tick));

  // R3
  ignored_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !ready) |=> $stable(hold_q));

  // R5
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> $past(tick));

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (tick),
  .load  (load),
  .ready (ready),
  .txd   (txd),
  .busy  (sh_busy),
  .hold_q(hold_q)
);

// File: tb/serial_tx_dbuf_bench.sv
module serial_tx_dbuf_bench;
  localparam int DW   = 5;
  localparam int OVS  = 16;
  localparam int TDIV = 2;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, load = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, irq_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic txd, ready, irq;

  int checks = 0, fails = 0, tdiv_cnt = 0;
  bit prev_tick = 0, mon_busy = 0;
  logic [DW-1:0] exp_q[$];
  bit gapless_q[$];

  serial_tx_dbuf #(.DATA_W(DW), .OVS(OVS)) u_serial_tx_dbuf (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .din(din),
    .cfg_par_en(par_en), .cfg_par_odd(par_odd), .cfg_two_stop(two_stop),
    .irq_en(irq_en), .txd(txd), .ready(ready), .irq(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv_cnt == TDIV - 1) begin tdiv_cnt = 0; tick = 1'b1; end
    else begin tdiv_cnt = tdiv_cnt + 1; tick = 1'b0; end
  end

  always @(posedge clk) prev_tick = tick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff tick == 1'b1);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [DW-1:0] v);
    load = 1'b1; din = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // line monitor: decodes frames at mid-bit points
  initial begin
    forever begin
      while (rst || txd !== 1'b0) @(negedge clk);
      mon_busy = 1;
      begin
        logic [DW-1:0] d;
        logic p, s1, s2, sb;
        logic [DW-1:0] e;
        check(prev_tick, "R5 start edge on tick", prev_tick, 1);
        check(exp_q.size() > 0, "R3 unexpected frame", exp_q.size(), 1);
        e = (exp_q.size() > 0) ? exp_q[0] : '0;
        wait_ticks(OVS / 2);
        sb = txd;
        check(sb == 1'b0, "R6 start bit low at mid", sb, 0);
        for (int i = 0; i < DW; i++) begin
          wait_ticks(OVS);
          d[i] = txd;
        end
        check(d == e, "R7 data bits", d, e);
        p = 1'b0;
        if (par_en) begin
          wait_ticks(OVS);
          p = txd;
          check((^{d, p}) == par_odd, "R8 parity", p, par_odd ^ (^d));
        end
        wait_ticks(OVS);
        s1 = txd;
        check(s1 == 1'b1, "R9 first stop", s1, 1);
        if (two_stop) begin
          wait_ticks(OVS);
          s2 = txd;
          check(s2 == 1'b1, "R9 second stop", s2, 1);
        end
        if (exp_q.size() > 0) begin void'(exp_q.pop_front()); void'(gapless_q.pop_front()); end
        wait_ticks(OVS / 2);
        if (gapless_q.size() > 0 && gapless_q[0])
          check(txd == 1'b0, "R4 gapless next start", txd, 0);
        else if (exp_q.size() == 0)
          check(txd == 1'b1, "R9 stop length then mark", txd, 1);
      end
      mon_busy = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(ready == 1'b1, "R1 reset ready", ready, 1);
    check(irq == 1'b0, "R10 irq disabled", irq, 0);
    rst = 1'b0;
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 irq enabled", irq, 1);
    for (int cfg = 0; cfg < 8; cfg++) begin
      par_en = cfg[0]; par_odd = cfg[1]; two_stop = cfg[2];
      for (int v = 0; v < (1 << DW); v += 2) begin
        int n;
        irq_en = v[1];
        @(negedge clk);
        exp_q.push_back(DW'(v)); gapless_q.push_back(0);
        do_load(DW'(v));
        check(ready == 1'b0, "R2 ready drops", ready, 0);
        check(irq == 1'b0, "R10 irq with ready low", irq, 0);
        n = 0;
        while (txd == 1'b1 && n < 10 * TDIV) begin @(negedge clk); n++; end
        check(n >= 1 && n <= TDIV, "R5 idle start latency", n, TDIV);
        check(ready == 1'b1, "R2 ready back at transfer", ready, 1);
        check(irq == irq_en, "R10 irq follows enable", irq, irq_en);
        exp_q.push_back(DW'(v + 1)); gapless_q.push_back(1);
        do_load(DW'(v + 1));
        check(ready == 1'b0, "R2 second load accepted", ready, 0);
        if (v % 8 == 4) begin
          do_load(DW'(~v));
          check(ready == 1'b0, "R3 ignored load keeps ready low", ready, 0);
        end
        wait (exp_q.size() == 0 && !mon_busy);
        repeat (3 * TDIV) @(negedge clk);
        check(txd == 1'b1 && ready == 1'b1, "R1 idle after pair", {txd, ready}, 3);
      end
    end
    report();
  end
endmodule